// File: doc/BRIEF.md
# ATA Task-File Register Unit

This block is the device side of one ATA channel. It holds the byte-wide task-file registers and the status and error registers. It runs the handshake that a host drives through programmed register reads and writes. The host gives an address and a read or write strobe. The unit then answers reads from a combinational read mux, and it updates its state on the clock edge that closes the access.

An IDENTIFY command streams a fixed block of 16-bit words through the data register, one word for each read, with DRQ held for the whole block. A DMA read or write command is handed to an external transfer engine. The unit stays BSY until that engine signals completion, then raises the interrupt line. A read of the status register acknowledges the interrupt. The number of units the port supports is a parameter. A unit number selected at or above that count is treated as absent.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x40 (DRDY only), the error register (offset 1) reads 0x00, irq is low and dma_req is low.
- R2: The sector count (offset 2), the three LBA bytes (offsets 3, 4, 5 for bits 7:0, 15:8, 23:16) and the device register (offset 6) read back the last value written to them. In the device register, bit 6 is the LBA-mode flag and bit 4 is the unit number.
- R3: The status byte, at offset 7 on reads, places BSY at 0x80, DRDY at 0x40, DF at 0x20, DRQ at 0x08 and ERR at 0x01. DF always reads as 0.
- R4: Command 0xEC, written to offset 7, starts an IDENTIFY transfer. Each of the ID_WORDS data reads (offset 0) returns word i of the ID source, in order from index 0, and sees status 0x48. After the last word, status reads 0x40.
- R5: A data-register read while DRQ is clear returns 0 and changes no state.
- R6: Command 0xC8 (read DMA) or 0xCA (write DMA) raises dma_req and makes status read 0xC0. dma_to_mem is 1 for 0xC8 and 0 for 0xCA.
- R7: A dma_done pulse while the unit is BSY drops dma_req, makes status read 0x40 and raises irq.
- R8: A status read lowers irq. Reads of any other register leave irq unchanged.
- R9: While BSY is set, command writes and task-file register writes are ignored.
- R10: Any other command code sets ERR (status 0x41), sets the abort bit (0x04) in the error register and raises irq. The next accepted command clears both.
- R11: When device-register bit 4 selects a unit number at or above NUM_UNITS, reads of the status, error and data registers return 0, and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Register read strobe, one cycle per access |
| host_wr | input | 1 | Register write strobe, one cycle per access |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 16 | Read data for the addressed register |
| id_addr | output | IDX_W | Index of the current IDENTIFY word |
| id_data | input | 16 | IDENTIFY word at id_addr |
| dma_req | output | 1 | DMA command handed to the transfer engine |
| dma_to_mem | output | 1 | Direction: 1 for device to memory |
| dma_done | input | 1 | Transfer engine completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. A status read clears the interrupt. DMA completion leaves the unit idle with the interrupt raised. A command written while BSY changes neither the busy state nor the direction. The last IDENTIFY word drops DRQ. A data read without DRQ returns zero. An unknown command leads to ERR and an interrupt. Other behaviour only the bench's scenarios can show: the word order and the status seen at every read of the 256-word block, register read-back, and the direction bit for each DMA code. The same holds for the abort code in the error register and the hiding of an absent unit.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter int NUM_UNITS = 1,
  parameter int ID_WORDS  = 256,
  localparam int IDX_W    = $clog2(ID_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [2:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [15:0]      host_rdata,
  output logic [IDX_W-1:0] id_addr,
  input  logic [15:0]      id_data,
  output logic             dma_req,
  output logic             dma_to_mem,
  input  logic             dma_done,
  output logic             irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);
  localparam logic [7:0] OP_RD_DMA = 8'hC8;
  localparam logic [7:0] OP_WR_DMA = 8'hCA;
  localparam logic [7:0] OP_IDENT  = 8'hEC;

  typedef enum logic [1:0] {ST_IDLE, ST_PIO, ST_DMA} st_t;

  st_t             st;
  logic [7:0]      cnt_q, lba_lo, lba_mid, lba_hi, dev_q;
  logic            err_q, abrt_q, irq_q, dir_q;
  logic [IDX_W-1:0] idx_q;

  logic bsy, drq, unit_ok, rd_stat, rd_word, wr_reg, wr_cmd, cmd_bad;
  logic [7:0] status, err_reg;

  assign bsy     = (st == ST_DMA);
  assign drq     = (st == ST_PIO);
  assign unit_ok = 32'(dev_q[4]) < NUM_UNITS;
  assign rd_stat = host_rd && host_addr == 3'd7 && unit_ok;
  assign rd_word = host_rd && host_addr == 3'd0 && unit_ok && drq;
  assign wr_reg  = host_wr && !bsy;
  assign wr_cmd  = wr_reg && host_addr == 3'd7 && unit_ok;
  assign cmd_bad = wr_cmd && host_wdata != OP_RD_DMA && host_wdata != OP_WR_DMA
                   && host_wdata != OP_IDENT;

  assign status  = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err_q};
  assign err_reg = {5'b0, abrt_q, 2'b00};

  assign id_addr    = idx_q;
  assign dma_req    = bsy;
  assign dma_to_mem = dir_q;
  assign irq        = irq_q;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      3'd0: host_rdata = (unit_ok && drq) ? id_data : 16'h0;
      3'd1: host_rdata = unit_ok ? {8'h0, err_reg} : 16'h0;
      3'd2: host_rdata = {8'h0, cnt_q};
      3'd3: host_rdata = {8'h0, lba_lo};
      3'd4: host_rdata = {8'h0, lba_mid};
      3'd5: host_rdata = {8'h0, lba_hi};
      3'd6: host_rdata = {8'h0, dev_q};
      3'd7: host_rdata = unit_ok ? {8'h0, status} : 16'h0;
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cnt_q <= '0; lba_lo <= '0; lba_mid <= '0; lba_hi <= '0; dev_q <= '0;
      err_q <= 1'b0; abrt_q <= 1'b0; irq_q <= 1'b0; dir_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (rd_stat) irq_q <= 1'b0;

      if (wr_reg) begin
        case (host_addr)
          3'd2: cnt_q   <= host_wdata;
          3'd3: lba_lo  <= host_wdata;
          3'd4: lba_mid <= host_wdata;
          3'd5: lba_hi  <= host_wdata;
          3'd6: dev_q   <= host_wdata;
          default: ;
        endcase
      end

      if (rd_word) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) st <= ST_IDLE;
      end

      if (bsy && dma_done) begin
        st    <= ST_IDLE;
        irq_q <= 1'b1;
      end

      if (wr_cmd) begin
        err_q  <= cmd_bad;
        abrt_q <= cmd_bad;
        case (host_wdata)
          OP_IDENT: begin
            st    <= ST_PIO;
            idx_q <= '0;
          end
          OP_RD_DMA, OP_WR_DMA: begin
            st    <= ST_DMA;
            dir_q <= (host_wdata == OP_RD_DMA);
          end
          default: begin
            st    <= ST_IDLE;
            irq_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_stat_read_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !host_wr && !(bsy && dma_done) |=> !irq);

  assert_dma_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_done |=> irq && !dma_req && !drq);

  assert_busy_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && host_wr && host_addr == 3'd7 && !dma_done |=> dma_req && $stable(dma_to_mem));

  assert_last_word_drops_drq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word && id_addr == LAST_IDX |=> !drq);

  assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 3'd0 && !drq |-> host_rdata == 16'h0);

  assert_bad_cmd_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> irq && host_rdata[0] == 1'b0 || err_q && irq);
endmodule

// File: tb/ata_taskfile_tb.sv
module ata_taskfile_tb;
  localparam int IDW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_rd = 1'b0, host_wr = 1'b0, dma_done = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [15:0] host_rdata, id_data;
  logic [IDW-1:0] id_addr;
  logic dma_req, dma_to_mem, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] rom(input int i);
    return {8'(i), ~8'(i)} ^ 16'h3C00;
  endfunction
  assign id_data = rom(int'(id_addr));

  ata_taskfile u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .id_addr(id_addr), .id_data(id_data), .dma_req(dma_req),
    .dma_to_mem(dma_to_mem), .dma_done(dma_done), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd7, v); chk("R1 status", v, 16'h40);
    rd(3'd1, v); chk("R1 error", v, 16'h00);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 dma_req", {15'b0, dma_req}, 16'h0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(3'd2, 8'h11); wr(3'd3, 8'hA5); wr(3'd4, 8'h5A); wr(3'd5, 8'h7E); wr(3'd6, 8'h40);
    rd(3'd2, v); chk("R2 count", v, 16'h11);
    rd(3'd3, v); chk("R2 lba lo", v, 16'hA5);
    rd(3'd4, v); chk("R2 lba mid", v, 16'h5A);
    rd(3'd5, v); chk("R2 lba hi", v, 16'h7E);
    rd(3'd6, v); chk("R2 device unit0", v, 16'h40);
  endtask

  task automatic t_identify;
    logic [15:0] v, s;
    int bad = 0;
    wr(3'd7, 8'hEC);
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, s);
      rd(3'd0, v);
      if (s !== 16'h48 || v !== rom(i)) begin
        bad++;
        if (bad < 4) begin
          chk("R4 word status", s, 16'h48);
          chk("R4 word data", v, rom(i));
        end
      end
    end
    chk("R4 all words", 16'(bad), 16'h0);
    rd(3'd7, v); chk("R4 final status R3", v, 16'h40);
    rd(3'd0, v); chk("R5 idle data read", v, 16'h0);
    rd(3'd7, v); chk("R5 status unchanged", v, 16'h40);
    chk("R4 no irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_dma(input logic [7:0] op, input logic dir);
    logic [15:0] v;
    wr(3'd7, op);
    chk("R6 dma_req", {15'b0, dma_req}, 16'h1);
    chk("R6 direction", {15'b0, dma_to_mem}, {15'b0, dir});
    rd(3'd7, v); chk("R6 busy status R3", v, 16'hC0);
    wr(3'd7, 8'hEC);
    chk("R9 cmd ignored dir", {15'b0, dma_to_mem}, {15'b0, dir});
    rd(3'd7, v); chk("R9 still busy", v, 16'hC0);
    wr(3'd3, 8'h99);
    rd(3'd3, v); chk("R9 reg write ignored", v, 16'hA5);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk("R7 irq", {15'b0, irq}, 16'h1);
    chk("R7 dma_req low", {15'b0, dma_req}, 16'h0);
    rd(3'd2, v); chk("R8 other read keeps irq", {15'b0, irq}, 16'h1);
    rd(3'd7, v); chk("R7 done status", v, 16'h40);
    chk("R8 status read clears irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_badcmd;
    logic [15:0] v;
    wr(3'd7, 8'h27);
    chk("R10 irq", {15'b0, irq}, 16'h1);
    rd(3'd1, v); chk("R10 abort bit", v, 16'h04);
    rd(3'd7, v); chk("R10 status", v, 16'h41);
    wr(3'd7, 8'hCA);
    rd(3'd7, v); chk("R10 err cleared", v, 16'hC0);
    rd(3'd1, v); chk("R10 error reg cleared", v, 16'h00);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    rd(3'd7, v);
  endtask

  task automatic t_unit;
    logic [15:0] v;
    wr(3'd6, 8'h50);
    rd(3'd6, v); chk("R11 device readback", v, 16'h50);
    rd(3'd7, v); chk("R11 absent status", v, 16'h0);
    wr(3'd7, 8'hC8);
    chk("R11 cmd ignored", {15'b0, dma_req}, 16'h0);
    wr(3'd7, 8'h27);
    chk("R11 bad cmd ignored", {15'b0, irq}, 16'h0);
    wr(3'd6, 8'h40);
    rd(3'd7, v); chk("R11 unit0 back", v, 16'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_identify;
    t_dma(8'hC8, 1'b1);
    t_dma(8'hCA, 1'b0);
    t_badcmd;
    t_unit;
    done = 1'b1;
    finish_up;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_up;
    end
  end
endmodule